// File: doc/BRIEF.md
# Dependence-Slot Rename Allocator

This block sits in the rename stage of one thread, on either the producing or the consuming side of a hardware inter-thread queue. Every produce or consume instruction arrives in program order with a static dependence number. The block answers in the same cycle with the slot index to use inside that dependence number's row, or with a stall. Each dependence number owns a private allocation pointer and a count of slots this side holds that the slot array has not yet handed back.

The producing side and the consuming side each run their own copy. Each slot is used by exactly one produce and one consume, and both sides see their own instructions in the same order. So the n-th produce and the n-th consume of a dependence number get the same slot index without looking anything up. A slot comes back to this side only when the array reports that it has returned to Empty. A misspeculation flush takes back the youngest allocations of one row: it moves that row's pointer back and drops those slots from the outstanding count.

Top module: `slot_rename_alloc`

## Requirements
- R1: After reset every row's pointer and outstanding count are zero. The first granted request on any dependence number gets slot 0. With no request, `alloc_grant` and `alloc_stall` are both low.
- R2: Successive grants on one dependence number return consecutive slot indices modulo `SLOT_COUNT` (slot `SLOT_COUNT-1` is followed by slot 0).
- R3: A grant, release or flush on one dependence number leaves the pointer and count of every other dependence number unchanged.
- R4: A request whose row holds `SLOT_COUNT` outstanding slots is stalled: `alloc_stall`=1 and `alloc_grant`=0. The row's pointer does not move, and the next grant on that row still returns the slot that was due.
- R5: Each cycle with `rel_valid` high returns one outstanding slot of row `rel_dep`, so a row that was full grants again after that cycle.
- R6: When a release and a request hit the same full row in the same cycle, both take effect and the request is granted in that cycle.
- R7: A flush of row `fl_dep` with count k moves that row's pointer back by k (modulo `SLOT_COUNT`) and lowers its outstanding count by k. The next grant on the row returns the old pointer minus k. k may be any value from 0 to the outstanding count.
- R8: In a cycle with `fl_valid` high, no request is granted, whatever its dependence number; a request present in that cycle sees `alloc_stall`=1.
- R9: When `alloc_req` is high, exactly one of `alloc_grant` and `alloc_stall` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | A produce/consume instruction asks for a slot |
| alloc_dep | input | $clog2(NUM_DEPS) | Dependence number of the request |
| rel_valid | input | 1 | The array reports one slot of a row back to Empty |
| rel_dep | input | $clog2(NUM_DEPS) | Dependence number of the released slot |
| fl_valid | input | 1 | Misspeculation flush of one row |
| fl_dep | input | $clog2(NUM_DEPS) | Dependence number being flushed |
| fl_count | input | $clog2(SLOT_COUNT)+1 | Number of youngest allocations taken back |
| alloc_grant | output | 1 | Request granted this cycle |
| alloc_stall | output | 1 | Request held back this cycle |
| alloc_slot | output | $clog2(SLOT_COUNT) | Slot index for the request (valid with grant) |

## Verification
The bench builds the block with 4 dependence numbers and 8 slots per row. With that setup, every row can be filled, stalled, wrapped past its last slot and fully flushed within a few dozen cycles. Directed sequences cover the filled row, a release and a request in the same cycle, and a flush that stalls the request beside it. A long pseudo-random sweep then mixes requests, releases and flushes of every legal size across all four rows. Every result is compared against pointers and counts that the bench works out arithmetically.

// File: rtl/sra_pkg.sv
// Package: default sizing shared by the slot rename allocator modules.
// Assumes SLOT_COUNT is a power of two so pointer wrap is a plain overflow.
package sra_pkg;
    localparam int DEF_NUM_DEPS   = 8;
    localparam int DEF_SLOT_COUNT = 32;
endpackage

// File: rtl/sra_row.sv
// Module: sra_row
// Holds the allocation pointer and outstanding count of one dependence row.
// Assumes: no allocation in a flush cycle (the grant logic guarantees it),
// and releases plus flush counts never exceed what is outstanding.
module sra_row #(
    parameter int SLOT_COUNT = sra_pkg::DEF_SLOT_COUNT,
    localparam int SW = $clog2(SLOT_COUNT),
    localparam int CW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_i,
    input  logic          free_i,
    input  logic          flush_i,
    input  logic [CW-1:0] flush_cnt_i,
    output logic [SW-1:0] ptr_o,
    output logic [CW-1:0] cnt_o
);
    logic [SW-1:0] ptr_q, ptr_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic [SW-1:0] rewind;
    logic [CW-1:0] drop;

    // Next pointer and count from allocation, release and flush together.
    always_comb begin
        rewind  = flush_i ? flush_cnt_i[SW-1:0] : '0;
        drop    = flush_i ? flush_cnt_i : '0;
        ptr_nxt = ptr_q + SW'(alloc_i) - rewind;
        cnt_nxt = cnt_q + CW'(alloc_i) - CW'(free_i) - drop;
    end

    // Row state register with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            ptr_q <= ptr_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    assign ptr_o = ptr_q;
    assign cnt_o = cnt_q;

    // R4: a row never holds more than SLOT_COUNT outstanding slots.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CW'(SLOT_COUNT));

    // R2: a grant advances this row's pointer by exactly one.
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> ptr_o == $past(ptr_o) + SW'(1));

    // R3: untouched rows keep their pointer.
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_i && !flush_i) |=> $stable(ptr_o));

    // R7: a flush moves the pointer back by its count.
    p_flush_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> ptr_o == $past(ptr_o) - $past(flush_cnt_i[SW-1:0]));

    // R5/R7: releases and flushes only return slots that are outstanding.
    p_return_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_i || flush_i) |->
            ({1'b0, drop} + (CW+1)'(free_i)) <= ({1'b0, cnt_o} + (CW+1)'(alloc_i)));
endmodule

// File: rtl/sra_grant.sv
// Module: sra_grant
// Decides grant or stall for the current request and selects its slot.
// Assumes the flat vectors carry row i at bit offset i*SW / i*CW.
module sra_grant #(
    parameter int NUM_DEPS   = sra_pkg::DEF_NUM_DEPS,
    parameter int SLOT_COUNT = sra_pkg::DEF_SLOT_COUNT,
    localparam int DW = $clog2(NUM_DEPS),
    localparam int SW = $clog2(SLOT_COUNT),
    localparam int CW = SW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic [DW-1:0]          dep_i,
    input  logic                   rel_i,
    input  logic [DW-1:0]          rel_dep_i,
    input  logic                   flush_i,
    input  logic [NUM_DEPS*SW-1:0] ptr_flat_i,
    input  logic [NUM_DEPS*CW-1:0] cnt_flat_i,
    output logic                   grant_o,
    output logic                   stall_o,
    output logic [SW-1:0]          slot_o
);
    logic [CW-1:0] cnt_sel;
    logic          row_full;
    logic          same_row_rel;

    // Room check: a full row is usable only if it releases a slot now.
    always_comb begin
        cnt_sel      = cnt_flat_i[dep_i*CW +: CW];
        row_full     = (cnt_sel == CW'(SLOT_COUNT));
        same_row_rel = rel_i && (rel_dep_i == dep_i);
        grant_o      = req_i && !flush_i && (!row_full || same_row_rel);
        stall_o      = req_i && !grant_o;
        slot_o       = ptr_flat_i[dep_i*SW +: SW];
    end

    // R9: an idle cycle produces neither grant nor stall.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> (!grant_o && !stall_o));

    // R8: flush cycles grant nothing.
    p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !grant_o);
endmodule

// File: rtl/slot_rename_alloc.sv
// Module: slot_rename_alloc (top)
// Per-side rename allocator: maps each in-order request of a dependence
// number to the next slot of that number's row, stalls when the row is
// exhausted, reclaims on release and rewinds on flush.
// Assumes in-order requests, legal release/flush counts, SLOT_COUNT a power
// of two, and a single side allocating per dependence number.
module slot_rename_alloc #(
    parameter int NUM_DEPS   = sra_pkg::DEF_NUM_DEPS,
    parameter int SLOT_COUNT = sra_pkg::DEF_SLOT_COUNT,
    localparam int DW = $clog2(NUM_DEPS),
    localparam int SW = $clog2(SLOT_COUNT),
    localparam int CW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic [DW-1:0] alloc_dep,
    input  logic          rel_valid,
    input  logic [DW-1:0] rel_dep,
    input  logic          fl_valid,
    input  logic [DW-1:0] fl_dep,
    input  logic [CW-1:0] fl_count,
    output logic          alloc_grant,
    output logic          alloc_stall,
    output logic [SW-1:0] alloc_slot
);
    logic [NUM_DEPS*SW-1:0] ptr_flat;
    logic [NUM_DEPS*CW-1:0] cnt_flat;

    // Grant decision and slot selection for the current request.
    sra_grant #(.NUM_DEPS(NUM_DEPS), .SLOT_COUNT(SLOT_COUNT)) u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (alloc_req),
        .dep_i      (alloc_dep),
        .rel_i      (rel_valid),
        .rel_dep_i  (rel_dep),
        .flush_i    (fl_valid),
        .ptr_flat_i (ptr_flat),
        .cnt_flat_i (cnt_flat),
        .grant_o    (alloc_grant),
        .stall_o    (alloc_stall),
        .slot_o     (alloc_slot)
    );

    // One state row per dependence number, with its own event decode.
    for (genvar d = 0; d < NUM_DEPS; d++) begin : g_row
        logic row_alloc, row_free, row_flush;

        // Steer the shared event inputs to this row.
        always_comb begin
            row_alloc = alloc_grant && (alloc_dep == DW'(d));
            row_free  = rel_valid   && (rel_dep   == DW'(d));
            row_flush = fl_valid    && (fl_dep    == DW'(d));
        end

        sra_row #(.SLOT_COUNT(SLOT_COUNT)) u_row (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (row_alloc),
            .free_i      (row_free),
            .flush_i     (row_flush),
            .flush_cnt_i (fl_count),
            .ptr_o       (ptr_flat[d*SW +: SW]),
            .cnt_o       (cnt_flat[d*CW +: CW])
        );
    end

    // R9: a request always resolves to exactly one outcome.
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> $countones({alloc_grant, alloc_stall}) == 1);
endmodule

// File: tb/slot_rename_alloc_test.sv
// Bench: small configuration (4 rows x 8 slots), directed corners then a
// pseudo-random sweep, all compared against an arithmetic model.
module slot_rename_alloc_test;
    localparam int ND = 4;
    localparam int NS = 8;
    localparam int DW = $clog2(ND);
    localparam int SW = $clog2(NS);
    localparam int CW = SW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic [DW-1:0] alloc_dep = '0;
    logic          rel_valid = 1'b0;
    logic [DW-1:0] rel_dep = '0;
    logic          fl_valid = 1'b0;
    logic [DW-1:0] fl_dep = '0;
    logic [CW-1:0] fl_count = '0;
    logic          alloc_grant, alloc_stall;
    logic [SW-1:0] alloc_slot;

    int n_checks = 0;
    int n_fail   = 0;
    int m_ptr [ND];
    int m_cnt [ND];
    int unsigned rng = 32'h1234_5678;

    always #10 clk = ~clk;

    slot_rename_alloc #(.NUM_DEPS(ND), .SLOT_COUNT(NS)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_dep(alloc_dep),
        .rel_valid(rel_valid), .rel_dep(rel_dep),
        .fl_valid(fl_valid), .fl_dep(fl_dep), .fl_count(fl_count),
        .alloc_grant(alloc_grant), .alloc_stall(alloc_stall),
        .alloc_slot(alloc_slot)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One cycle: drive at negedge, check before posedge, advance model.
    task automatic step(input bit rq, input int dp, input bit rv, input int rd,
                        input bit fv, input int fd, input int fc, input string tag);
        bit eg;
        @(negedge clk);
        alloc_req = rq; alloc_dep = DW'(dp);
        rel_valid = rv; rel_dep = DW'(rd);
        fl_valid = fv;  fl_dep = DW'(fd); fl_count = CW'(fc);
        #2;
        eg = rq && !fv && (m_cnt[dp] < NS || (rv && rd == dp));
        chk(alloc_grant == eg, {tag, " grant"}, int'(alloc_grant), int'(eg));
        chk(alloc_stall == (rq && !eg), {tag, " stall"}, int'(alloc_stall), int'(rq && !eg));
        if (eg) chk(int'(alloc_slot) == m_ptr[dp], {tag, " slot"}, int'(alloc_slot), m_ptr[dp]);
        if (fv) begin
            m_ptr[fd] = (m_ptr[fd] - fc + NS) % NS;
            m_cnt[fd] = m_cnt[fd] - fc;
        end
        if (rv) m_cnt[rd] = m_cnt[rd] - 1;
        if (eg) begin
            m_ptr[dp] = (m_ptr[dp] + 1) % NS;
            m_cnt[dp] = m_cnt[dp] + 1;
        end
        @(posedge clk);
    endtask

    function automatic int unsigned nxt();
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
        return rng;
    endfunction

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int d = 0; d < ND; d++) begin m_ptr[d] = 0; m_cnt[d] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1/R9: idle after reset gives neither grant nor stall.
        step(0, 0, 0, 0, 0, 0, 0, "R1 idle");
        // R1: first request of every row gets slot 0.
        for (int d = 0; d < ND; d++) step(1, d, 0, 0, 0, 0, 0, "R1 first");
        // R2/R3: interleaved fill of all rows, consecutive slots per row.
        for (int i = 1; i < NS; i++)
            for (int d = 0; d < ND; d++) step(1, d, 0, 0, 0, 0, 0, "R2 R3 fill");
        // R4: every full row stalls, repeatedly.
        for (int d = 0; d < ND; d++) begin
            step(1, d, 0, 0, 0, 0, 0, "R4 full");
            step(1, d, 0, 0, 0, 0, 0, "R4 full again");
        end
        // R6: release and request on full row 0 in one cycle -> slot 0 (wrap, R2).
        step(1, 0, 1, 0, 0, 0, 0, "R6 R2 same-cycle wrap");
        // R5: release row 1, then row 1 grants again.
        step(0, 0, 1, 1, 0, 0, 0, "R5 release");
        step(1, 1, 0, 0, 0, 0, 0, "R5 regrant");
        // R3: release on row 2 does not let row 3 grant.
        step(1, 3, 1, 2, 0, 0, 0, "R3 other row");
        // R8: flush row 2 by 3 while row 0 requests.
        step(1, 0, 0, 0, 1, 2, 3, "R8 flush blocks");
        // R7: row 2 next grant returns rewound slot.
        step(1, 2, 0, 0, 0, 0, 0, "R7 rewound slot");
        // R7: full flush of row 3 then refill all slots.
        step(0, 0, 0, 0, 1, 3, NS, "R7 full flush");
        for (int i = 0; i < NS + 1; i++) step(1, 3, 0, 0, 0, 0, 0, "R7 R4 refill");
        // R7: zero-count flush changes nothing.
        step(0, 0, 0, 0, 1, 1, 0, "R7 zero flush");
        step(1, 1, 0, 0, 0, 0, 0, "R7 after zero flush");

        // Sweep: legal random mix of requests, releases and flushes.
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = nxt();
            bit rq = r[0] | r[1];
            int dp = int'(r[3:2]);
            bit fv = (r[7:4] == 4'd0);
            int fd = int'(r[9:8]);
            int fc = (m_cnt[fd] == 0) ? 0 : int'(r[15:12]) % (m_cnt[fd] + 1);
            int rd = int'(r[11:10]);
            bit rv = r[16] && (m_cnt[rd] > ((fv && fd == rd) ? fc : 0));
            step(rq, dp, rv, rd, fv, fd, fc, "R2 R3 R4 R5 R6 R7 R8 R9 sweep");
        end
        finish_run();
    end
endmodule